// File: doc/BRIEF.md
# Serial EEPROM Protect Register Unit

This unit decides, for a MICROWIRE-style serial EEPROM with 128 word locations of 16 bits, whether each decoded instruction may take effect. A programmable boundary register marks the lowest read-only address. Every location from that boundary up to address 127 refuses write and erase. A separate write-enable latch guards the whole array, so the device comes up refusing all modifications until software asks to allow them.

The boundary itself is guarded. It can be reprogrammed only while an external protect-enable pin is high and a protect-enable instruction has armed a one-shot latch. The same guard applies to the lock instruction, which sets a one-time cell that freezes the boundary for good. The boundary and the lock cell model non-volatile state. They survive the soft reset input and return to their initial values only on the power-on initialisation input.

A serial front end presents one decoded instruction per `cmdValid` cycle. The unit answers one clock later with a granted or refused flag and exposes its latches and the boundary.

Top module: `eep_prot_unit`

## Requirements
- R1: After power-on initialisation (`porN` low), the write-enable latch and protect-enable latch read 0, the boundary reads 127, the lock cell reads 0, and `respValid` is 0.
- R2: The `cmdOp` encoding is: 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 protect-enable, 6 boundary load (new value on `cmdAddr`), 7 lock. Every command is answered in the next cycle, with `respValid`=1 and exactly one of `respOk` or `respDenied` set. Write-enable, write-disable and protect-enable are always granted.
- R3: Write-enable sets the write-enable latch and write-disable clears it. A write or erase is refused while the latch is clear.
- R4: With the write-enable latch set, a write or erase is granted when `cmdAddr` is below the boundary and refused when `cmdAddr` is at or above it.
- R5: A read is always granted, whatever its address and the state of the latches.
- R6: Protect-enable sets the protect-enable latch. A boundary load takes effect only when `pinProtEn` is 1, the protect-enable latch is set and the lock cell is clear. Otherwise it is refused and the boundary is unchanged.
- R7: A successful boundary load or lock clears the protect-enable latch, so the next such operation needs a fresh protect-enable.
- R8: A lock sets the lock cell under the same condition as a boundary load. Once the cell is set, every boundary load and lock is refused, and the boundary never changes again until power-on initialisation.
- R9: A soft reset (`rstN` low) clears both enable latches and the response, but it keeps the boundary and the lock cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Soft reset, active low, asynchronous |
| porN | input | 1 | Power-on initialisation, active low, asynchronous |
| cmdValid | input | 1 | A decoded instruction is present this cycle |
| cmdOp | input | 3 | Instruction code |
| cmdAddr | input | 7 | Access address, or the new boundary for a load |
| pinProtEn | input | 1 | External protect-enable pin |
| respValid | output | 1 | A decision is presented |
| respOk | output | 1 | The instruction was granted |
| respDenied | output | 1 | The instruction was refused |
| wrEnLatch | output | 1 | Write-enable latch state |
| protEnLatch | output | 1 | Protect-enable latch state |
| boundAddr | output | 7 | First protected address |
| lockCell | output | 1 | One-time lock cell state |

## Verification
The assertions assume that `cmdOp` and `cmdAddr` are settled whenever `cmdValid` is high. They also assume that the two reset inputs are driven away from the active clock edge. The bench drives every input at the falling edge and holds it for a full cycle. It pulses the resets only between commands, and it keeps `pinProtEn` high on most random commands so that the guarded boundary path is reached often. Random opcodes cover all eight codes and the whole address range, so lock events occur during the random phase. The reference model tracks those lock events rather than assuming they do not happen.

// File: rtl/eep_prot_pkg.sv
package eep_prot_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ERASE  = 3'd2,
    OP_WREN   = 3'd3,
    OP_WRDIS  = 3'd4,
    OP_PREN   = 3'd5,
    OP_PRLOAD = 3'd6,
    OP_PRLOCK = 3'd7
  } protOp_t;

  typedef struct packed {
    logic loadBound;
    logic setLock;
  } dpStrobe_t;

endpackage

// File: rtl/eep_prot_ctrl.sv
module eep_prot_ctrl
  import eep_prot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      porN,
  input  logic      cmdValid,
  input  protOp_t   cmdOp,
  input  logic      pinProtEn,
  input  logic      addrInZone,
  input  logic      lockCell,
  output dpStrobe_t strobe,
  output logic      wenQ,
  output logic      penQ,
  output logic      respValid,
  output logic      respOk,
  output logic      respDenied
);

  logic progOk;
  logic opOk;

  assign progOk = pinProtEn && penQ && !lockCell;

  always_comb begin
    opOk = 1'b1;
    case (cmdOp)
      OP_WRITE, OP_ERASE:   opOk = wenQ && !addrInZone;
      OP_PRLOAD, OP_PRLOCK: opOk = progOk;
      default:              opOk = 1'b1;
    endcase
  end

  assign strobe.loadBound = cmdValid && (cmdOp == OP_PRLOAD) && progOk;
  assign strobe.setLock   = cmdValid && (cmdOp == OP_PRLOCK) && progOk;

  always_ff @(posedge clk or negedge rstN or negedge porN) begin
    if (!rstN || !porN) begin
      wenQ       <= 1'b0;
      penQ       <= 1'b0;
      respValid  <= 1'b0;
      respOk     <= 1'b0;
      respDenied <= 1'b0;
    end else begin
      respValid  <= cmdValid;
      respOk     <= cmdValid && opOk;
      respDenied <= cmdValid && !opOk;
      if (cmdValid && cmdOp == OP_WREN)  wenQ <= 1'b1;
      if (cmdValid && cmdOp == OP_WRDIS) wenQ <= 1'b0;
      if (strobe.loadBound || strobe.setLock) penQ <= 1'b0;
      else if (cmdValid && cmdOp == OP_PREN) penQ <= 1'b1;
    end
  end

  // R3
  wr_blocked_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cmdValid && (cmdOp == OP_WRITE || cmdOp == OP_ERASE) && !wenQ) |=> respDenied);

  // R5
  read_granted_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cmdValid && cmdOp == OP_READ) |=> respOk);

  // R7
  pen_consumed_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (strobe.loadBound || strobe.setLock) |=> !penQ);

  // R2
  resp_single_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    respValid |-> $countones({respOk, respDenied}) == 1);

endmodule

// File: rtl/eep_prot_dp.sv
module eep_prot_dp
  import eep_prot_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              porN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              addrInZone,
  output logic [ADDR_W-1:0] boundQ,
  output logic              lockQ
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  assign addrInZone = (cmdAddr >= boundQ);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      boundQ <= TOP_ADDR;
      lockQ  <= 1'b0;
    end else if (!lockQ) begin
      if (strobe.loadBound) boundQ <= cmdAddr;
      if (strobe.setLock)   lockQ  <= 1'b1;
    end
  end

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    lockQ |=> lockQ);

  // R8
  bound_frozen_chk: assert property (@(posedge clk) disable iff (!porN)
    lockQ |=> $stable(boundQ));

  // R6
  bound_guard_chk: assert property (@(posedge clk) disable iff (!porN)
    !strobe.loadBound |=> $stable(boundQ));

endmodule

// File: rtl/eep_prot_unit.sv
module eep_prot_unit
  import eep_prot_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              pinProtEn,
  output logic              respValid,
  output logic              respOk,
  output logic              respDenied,
  output logic              wrEnLatch,
  output logic              protEnLatch,
  output logic [ADDR_W-1:0] boundAddr,
  output logic              lockCell
);

  dpStrobe_t strobe;
  logic      addrInZone;
  protOp_t   opDec;

  assign opDec = protOp_t'(cmdOp);

  eep_prot_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .porN       (porN),
    .cmdValid   (cmdValid),
    .cmdOp      (opDec),
    .pinProtEn  (pinProtEn),
    .addrInZone (addrInZone),
    .lockCell   (lockCell),
    .strobe     (strobe),
    .wenQ       (wrEnLatch),
    .penQ       (protEnLatch),
    .respValid  (respValid),
    .respOk     (respOk),
    .respDenied (respDenied)
  );

  eep_prot_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .porN       (porN),
    .strobe     (strobe),
    .cmdAddr    (cmdAddr),
    .addrInZone (addrInZone),
    .boundQ     (boundAddr),
    .lockQ      (lockCell)
  );

endmodule

// File: tb/test_eep_prot_unit.sv
module test_eep_prot_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       porN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [6:0] cmdAddr = 7'd0;
  logic       pinProtEn = 1'b0;
  logic       respValid, respOk, respDenied;
  logic       wrEnLatch, protEnLatch, lockCell;
  logic [6:0] boundAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit       mWen, mPen, mLock;
  bit [6:0] mBound;

  always #2.5 clk = ~clk;

  eep_prot_unit i_eep_prot_unit (
    .clk(clk), .rstN(rstN), .porN(porN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .pinProtEn(pinProtEn), .respValid(respValid),
    .respOk(respOk), .respDenied(respDenied), .wrEnLatch(wrEnLatch),
    .protEnLatch(protEnLatch), .boundAddr(boundAddr), .lockCell(lockCell)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expGrant(input bit [2:0] op, input bit [6:0] a, input bit pin);
    case (op)
      3'd1, 3'd2: return mWen && (a < mBound);
      3'd6, 3'd7: return pin && mPen && !mLock;
      default:    return 1'b1;
    endcase
  endfunction

  function automatic string respTag(input bit [2:0] op);
    case (op)
      3'd0:       return "R5";
      3'd1, 3'd2: return "R4";
      3'd6:       return "R6";
      3'd7:       return "R8";
      default:    return "R2";
    endcase
  endfunction

  task automatic checkState(input string ctx);
    check(wrEnLatch == mWen, "R3", {ctx, " wen"}, wrEnLatch, mWen);
    check(protEnLatch == mPen, "R7", {ctx, " pen"}, protEnLatch, mPen);
    check(boundAddr == mBound, "R6", {ctx, " bound"}, boundAddr, mBound);
    check(lockCell == mLock, "R8", {ctx, " lock"}, lockCell, mLock);
  endtask

  task automatic runOp(input bit [2:0] op, input bit [6:0] a, input bit pin);
    bit ok;
    ok = expGrant(op, a, pin);
    case (op)
      3'd3: mWen = 1'b1;
      3'd4: mWen = 1'b0;
      3'd5: mPen = 1'b1;
      3'd6: if (ok) begin mBound = a; mPen = 1'b0; end
      3'd7: if (ok) begin mLock = 1'b1; mPen = 1'b0; end
      default: ;
    endcase
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; pinProtEn = pin;
    @(negedge clk);
    cmdValid = 1'b0;
    check(respValid == 1'b1, "R2", "respValid", respValid, 1);
    check(respOk == ok, respTag(op), $sformatf("respOk op=%0d addr=%0d", op, a), respOk, ok);
    check(respDenied == !ok, respTag(op), "respDenied", respDenied, !ok);
    checkState($sformatf("after op=%0d", op));
  endtask

  task automatic powerOn();
    @(negedge clk); porN = 1'b0; rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    mWen = 0; mPen = 0; mLock = 0; mBound = 7'd127;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    mWen = 0; mPen = 0; mLock = 0; mBound = 7'd127;
    @(negedge clk); @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R1 initial state
    check(respValid == 1'b0, "R1", "respValid", respValid, 0);
    checkState("R1 power-on");
    check(boundAddr == 7'd127, "R1", "bound", boundAddr, 127);

    runOp(3'd0, 7'd127, 1'b0);   // R5 read at top
    runOp(3'd1, 7'd5, 1'b1);     // R3 write refused, latch clear
    runOp(3'd2, 7'd5, 1'b1);     // R3 erase refused
    runOp(3'd3, 7'd0, 1'b0);     // R3 write-enable
    runOp(3'd1, 7'd5, 1'b0);     // R4 below bound
    runOp(3'd1, 7'd127, 1'b0);   // R4 at bound
    runOp(3'd5, 7'd0, 1'b0);     // R6 arm
    runOp(3'd6, 7'd64, 1'b0);    // R6 pin low refused
    runOp(3'd6, 7'd64, 1'b1);    // R6 load ok
    runOp(3'd6, 7'd80, 1'b1);    // R7 needs fresh enable
    runOp(3'd1, 7'd63, 1'b0);    // R4 just below
    runOp(3'd1, 7'd64, 1'b0);    // R4 at boundary
    runOp(3'd2, 7'd100, 1'b0);   // R4 above
    runOp(3'd0, 7'd100, 1'b0);   // R5 read protected
    runOp(3'd4, 7'd0, 1'b0);     // R3 write-disable
    runOp(3'd1, 7'd10, 1'b0);    // R3 refused again

    // R9 soft reset keeps boundary
    runOp(3'd3, 7'd0, 1'b0);
    runOp(3'd5, 7'd0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mWen = 0; mPen = 0;
    @(negedge clk);
    check(respValid == 1'b0, "R9", "respValid", respValid, 0);
    check(wrEnLatch == 1'b0, "R9", "wen", wrEnLatch, 0);
    check(protEnLatch == 1'b0, "R9", "pen", protEnLatch, 0);
    check(boundAddr == 7'd64, "R9", "bound kept", boundAddr, 64);

    // random phase
    for (int i = 0; i < 400; i++) begin
      bit [2:0] op;
      bit [6:0] a;
      bit pin;
      op  = 3'($urandom_range(0, 7));
      a   = 7'($urandom_range(0, 127));
      pin = ($urandom_range(0, 3) != 0);
      runOp(op, a, pin);
    end

    // R8 lock then frozen
    powerOn();
    runOp(3'd5, 7'd0, 1'b1);
    runOp(3'd6, 7'd32, 1'b1);
    runOp(3'd5, 7'd0, 1'b1);
    runOp(3'd7, 7'd0, 1'b1);     // R8 lock ok
    runOp(3'd5, 7'd0, 1'b1);
    runOp(3'd6, 7'd10, 1'b1);    // R8 refused after lock
    runOp(3'd7, 7'd0, 1'b1);     // R8 second lock refused
    runOp(3'd3, 7'd0, 1'b0);
    runOp(3'd1, 7'd31, 1'b0);    // R4 below frozen boundary
    runOp(3'd1, 7'd32, 1'b0);    // R4 at frozen boundary
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mWen = 0; mPen = 0;
    @(negedge clk);
    check(lockCell == 1'b1, "R9", "lock kept", lockCell, 1);
    check(boundAddr == 7'd32, "R9", "bound kept locked", boundAddr, 32);

    // R9 power-on clears lock
    powerOn();
    check(lockCell == 1'b0, "R9", "lock cleared by por", lockCell, 0);
    check(boundAddr == 7'd127, "R1", "bound after por", boundAddr, 127);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule